// File: doc/BRIEF.md
# Windowed Frame Memory Address Pointer

This block produces write addresses for a display RAM of 240 columns by 320 rows. Writes are confined to a rectangular window. It keeps two independent position pointers. One serves a serial command port and the other a parallel pixel port. A single select input decides which of the two ports may write.

Each pointer walks the window along its major axis (X) first. After X passes its upper bound, the pointer returns to the X lower bound and steps the minor axis (Y). When the last cell of the window has been written, each pointer either restarts at the window origin or refuses further writes until it is reset. Each port has its own mode input for this choice, and the two inputs use opposite polarities.

An axis-swap input and two mirror inputs map the logical (X, Y) position onto physical RAM coordinates. Every accepted pixel produces one registered write-enable pulse together with its linear address. Pixel data, timing generation and the RAM are outside this block.

Top module: `win_addr_ptr`

## Requirements
- R1: The RAM address is physical_row*240 + physical_column. A start strobe followed by a serial pixel writes at the window origin, which is address ys*240+xs when axis swap and both mirrors are 0.
- R2: After each accepted pixel the pointer steps X by one. When X equals the X upper bound, X returns to the X lower bound and Y steps by one.
- R3: With the serial wrap input at 1, the serial pixel that follows a write at (xe, ye) lands at the window origin.
- R4: With the serial wrap input at 0, serial pixels after the write at (xe, ye) are refused. A continue strobe does not lift this. Only the first pixel after a new start strobe is written, and it goes to the window origin.
- R5: A start strobe that no pixel follows leaves the serial pointer unchanged. A later continue strobe cancels the pending restart, and the next serial pixel resumes where the pointer was.
- R6: A continue strobe resumes the serial pointer at the cell after the last serial write. Parallel writes in between do not move it.
- R7: With the parallel stall input at 1, parallel pixels after the write at (xe, ye) are refused. With it at 0, the next parallel pixel lands at the window origin.
- R8: A frame sync pulse moves the parallel pointer to the window origin only when the select input is 1 and the parallel stall input is 1. Otherwise it has no effect.
- R9: In the cycle where the select input goes from 0 to 1, the parallel pointer moves to the window origin and any stall is cleared, whatever the stall input is.
- R10: A select value of 0 grants writes to the serial port and 1 grants them to the parallel port. A pixel from the other port produces no write and does not move that port's pointer.
- R11: With axis swap at 0, X is the physical column (maximum 239) and Y is the physical row (maximum 319). With axis swap at 1, X is the row (maximum 319) and Y is the column. A bound above its axis maximum is clamped to that maximum.
- R12: With the column mirror at 1, the physical column becomes 239 minus the column. With the row mirror at 1, the physical row becomes 319 minus the row.
- R13: Write enable is high for exactly the one cycle after the cycle in which a pixel is accepted, with its address alongside. Out of reset, write enable is 0 and the address is 0.
- R14: A pointer reset in the same cycle as a pixel on that port takes effect first, so the pixel is written at the window origin. The reset may be a start strobe with a serial pixel, or a qualifying frame sync or select rise with a parallel pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_xs | input | 9 | X lower bound |
| win_xe | input | 9 | X upper bound |
| win_ys | input | 9 | Y lower bound |
| win_ye | input | 9 | Y upper bound |
| mode_swap | input | 1 | 1: X runs along rows |
| mirror_col | input | 1 | Reflect physical column |
| mirror_row | input | 1 | Reflect physical row |
| sel_par | input | 1 | 0: serial port writes, 1: parallel port writes |
| ser_wrap | input | 1 | Serial end-of-window: 1 wrap, 0 stall |
| par_stall | input | 1 | Parallel end-of-window: 1 stall, 0 wrap |
| ser_start | input | 1 | Start-write strobe (restart deferred to first pixel) |
| ser_cont | input | 1 | Continue-write strobe |
| ser_pix | input | 1 | Serial pixel valid |
| par_pix | input | 1 | Parallel pixel valid |
| frame_sync | input | 1 | Frame sync pulse |
| ram_addr | output | 17 | Linear write address |
| ram_we | output | 1 | Write enable |

## Verification
Two functions can land in the same clock: a pointer reset and a pixel on the same port. On the parallel port the reset is a frame sync with stall set, or the select rise. On the serial port it is a start strobe. The bench first advances each pointer away from the origin. It then drives the reset and the pixel in a single cycle. The pass condition is that the written address is the window origin, not the advanced position. The complementary cases are also driven: a frame sync with stall clear, and a start strobe cancelled by a continue strobe. In both, the bench checks that the next address continues from the advanced position.

// File: rtl/win_addr_ptr.sv
module win_addr_ptr #(
  parameter int COLS = 240,
  parameter int ROWS = 320,
  localparam int CW = $clog2((COLS > ROWS) ? COLS : ROWS),
  localparam int AW = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] win_xs,
  input  logic [CW-1:0] win_xe,
  input  logic [CW-1:0] win_ys,
  input  logic [CW-1:0] win_ye,
  input  logic          mode_swap,
  input  logic          mirror_col,
  input  logic          mirror_row,
  input  logic          sel_par,
  input  logic          ser_wrap,
  input  logic          par_stall,
  input  logic          ser_start,
  input  logic          ser_cont,
  input  logic          ser_pix,
  input  logic          par_pix,
  input  logic          frame_sync,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we
);

  localparam logic [CW-1:0] CMAX = CW'(COLS - 1);
  localparam logic [CW-1:0] RMAX = CW'(ROWS - 1);

  function automatic logic [2*CW:0] step_pos(input logic [CW-1:0] x, y, xs, xe, ys, ye);
    if (x != xe) return {1'b0, y, CW'(x + CW'(1))};
    if (y != ye) return {1'b0, CW'(y + CW'(1)), xs};
    return {1'b1, ys, xs};
  endfunction

  logic [CW-1:0] xmax, ymax, xs_c, xe_c, ys_c, ye_c;
  assign xmax = mode_swap ? RMAX : CMAX;
  assign ymax = mode_swap ? CMAX : RMAX;
  assign xs_c = (win_xs > xmax) ? xmax : win_xs;
  assign xe_c = (win_xe > xmax) ? xmax : win_xe;
  assign ys_c = (win_ys > ymax) ? ymax : win_ys;
  assign ye_c = (win_ye > ymax) ? ymax : win_ye;

  // serial pointer
  logic [CW-1:0] s_x, s_y, s_cx, s_cy;
  logic          s_pend, s_halt, s_pend_eff, s_go;
  logic [2*CW:0] s_nxt;

  assign s_pend_eff = ser_start | (s_pend & ~ser_cont);
  assign s_cx       = s_pend_eff ? xs_c : s_x;
  assign s_cy       = s_pend_eff ? ys_c : s_y;
  assign s_go       = ser_pix & ~sel_par & (s_pend_eff | ~s_halt);
  assign s_nxt      = step_pos(s_cx, s_cy, xs_c, xe_c, ys_c, ye_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_x    <= '0;
      s_y    <= '0;
      s_pend <= 1'b0;
      s_halt <= 1'b0;
    end else if (s_go) begin
      s_x    <= s_nxt[CW-1:0];
      s_y    <= s_nxt[2*CW-1:CW];
      s_pend <= 1'b0;
      s_halt <= s_nxt[2*CW] & ~ser_wrap;
    end else begin
      s_pend <= s_pend_eff;
    end
  end

  // parallel pointer
  logic [CW-1:0] p_x, p_y, p_cx, p_cy;
  logic          p_halt, sel_q, p_rst, p_go;
  logic [2*CW:0] p_nxt;

  assign p_rst = sel_par & (~sel_q | (frame_sync & par_stall));
  assign p_cx  = p_rst ? xs_c : p_x;
  assign p_cy  = p_rst ? ys_c : p_y;
  assign p_go  = par_pix & sel_par & (p_rst | ~p_halt);
  assign p_nxt = step_pos(p_cx, p_cy, xs_c, xe_c, ys_c, ye_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_x    <= '0;
      p_y    <= '0;
      p_halt <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      sel_q <= sel_par;
      if (p_go) begin
        p_x    <= p_nxt[CW-1:0];
        p_y    <= p_nxt[2*CW-1:CW];
        p_halt <= p_nxt[2*CW] & par_stall;
      end else if (p_rst) begin
        p_x    <= xs_c;
        p_y    <= ys_c;
        p_halt <= 1'b0;
      end
    end
  end

  // physical mapping
  logic [CW-1:0] cx, cy, col_l, row_l, pcol, prow;
  logic          go;

  assign go    = s_go | p_go;
  assign cx    = sel_par ? p_cx : s_cx;
  assign cy    = sel_par ? p_cy : s_cy;
  assign col_l = mode_swap ? cy : cx;
  assign row_l = mode_swap ? cx : cy;
  assign pcol  = mirror_col ? CW'(CMAX - col_l) : col_l;
  assign prow  = mirror_row ? CW'(RMAX - row_l) : row_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we   <= 1'b0;
      ram_addr <= '0;
    end else begin
      ram_we <= go;
      if (go) ram_addr <= AW'(AW'(prow) * AW'(COLS) + AW'(pcol));
    end
  end

endmodule

// File: rtl/win_addr_ptr_chk.sv
module win_addr_ptr_chk #(
  parameter int COLS = 240,
  parameter int ROWS = 320,
  localparam int CW = $clog2((COLS > ROWS) ? COLS : ROWS),
  localparam int AW = $clog2(COLS * ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] win_xs,
  input logic [CW-1:0] win_xe,
  input logic [CW-1:0] win_ys,
  input logic [CW-1:0] win_ye,
  input logic          mode_swap,
  input logic          mirror_col,
  input logic          mirror_row,
  input logic          sel_par,
  input logic          par_stall,
  input logic          ser_start,
  input logic          ser_pix,
  input logic          par_pix,
  input logic          frame_sync,
  input logic [AW-1:0] ram_addr,
  input logic          ram_we
);

  logic plain_win;
  assign plain_win = !mode_swap && !mirror_col && !mirror_row &&
                     win_xs <= win_xe && win_xe < CW'(COLS) &&
                     win_ys <= win_ye && win_ye < CW'(ROWS);

  // R13
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_pix && !par_pix) |=> !ram_we);

  // R10
  serial_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_pix && sel_par && !par_pix) |=> !ram_we);

  // R10
  parallel_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_pix && !sel_par && !ser_pix) |=> !ram_we);

  // R11
  addr_in_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr < AW'(COLS * ROWS)));

  // R14
  start_with_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_pix && ser_start && !sel_par && plain_win) |=>
      (ram_we && ram_addr == AW'(AW'($past(win_ys)) * AW'(COLS) + AW'($past(win_xs)))));

  // R8
  sync_with_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_pix && sel_par && frame_sync && par_stall && plain_win) |=>
      (ram_we && ram_addr == AW'(AW'($past(win_ys)) * AW'(COLS) + AW'($past(win_xs)))));

endmodule

bind win_addr_ptr win_addr_ptr_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_xs(win_xs), .win_xe(win_xe),
  .win_ys(win_ys), .win_ye(win_ye), .mode_swap(mode_swap),
  .mirror_col(mirror_col), .mirror_row(mirror_row), .sel_par(sel_par),
  .par_stall(par_stall), .ser_start(ser_start), .ser_pix(ser_pix),
  .par_pix(par_pix), .frame_sync(frame_sync), .ram_addr(ram_addr),
  .ram_we(ram_we)
);

// File: tb/win_addr_ptr_test.sv
module win_addr_ptr_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [8:0]  win_xs, win_xe, win_ys, win_ye;
  logic        mode_swap, mirror_col, mirror_row, sel_par, ser_wrap, par_stall;
  logic        ser_start, ser_cont, ser_pix, par_pix, frame_sync;
  logic [16:0] ram_addr;
  logic        ram_we;

  int tests = 0;
  int fails = 0;

  win_addr_ptr uut (.*);

  task automatic step(input logic sp, pp, fs, st, ct);
    ser_pix = sp; par_pix = pp; frame_sync = fs; ser_start = st; ser_cont = ct;
    @(negedge clk);
    ser_pix = 0; par_pix = 0; frame_sync = 0; ser_start = 0; ser_cont = 0;
  endtask

  task automatic exp_wr(input string req, input int a);
    tests++;
    if (ram_we !== 1'b1 || int'(ram_addr) != a) begin
      fails++;
      $display("FAIL %s: we=%0b addr=%0d expected we=1 addr=%0d", req, ram_we, ram_addr, a);
    end
  endtask

  task automatic exp_none(input string req);
    tests++;
    if (ram_we !== 1'b0) begin
      fails++;
      $display("FAIL %s: we=%0b expected we=0", req, ram_we);
    end
  endtask

  task automatic set_win(input int xs, xe, ys, ye);
    win_xs = 9'(xs); win_xe = 9'(xe); win_ys = 9'(ys); win_ye = 9'(ye);
  endtask

  task automatic t_reset;
    tests++;
    if (ram_we !== 1'b0 || ram_addr !== '0) begin
      fails++;
      $display("FAIL R13: we=%0b addr=%0d expected we=0 addr=0", ram_we, ram_addr);
    end
  endtask

  task automatic t_serial_wrap;
    sel_par = 0; ser_wrap = 1; set_win(2, 4, 5, 6);
    step(0, 0, 0, 1, 0);
    exp_none("R5");
    step(1, 0, 0, 0, 0); exp_wr("R1", 1202);
    step(1, 0, 0, 0, 0); exp_wr("R2", 1203);
    step(0, 0, 0, 0, 0); exp_none("R13");
    step(1, 0, 0, 0, 0); exp_wr("R2", 1204);
    step(1, 0, 0, 0, 0); exp_wr("R2", 1442);
    step(1, 0, 0, 0, 0); exp_wr("R2", 1443);
    step(1, 0, 0, 0, 0); exp_wr("R2", 1444);
    step(1, 0, 0, 0, 0); exp_wr("R3", 1202);
  endtask

  task automatic t_serial_stall;
    sel_par = 0; ser_wrap = 0; set_win(2, 4, 5, 6);
    step(0, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0);
    exp_wr("R4", 1444);
    step(1, 0, 0, 0, 0); exp_none("R4");
    step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0); exp_none("R4");
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0); exp_wr("R4", 1202);
    ser_wrap = 1;
  endtask

  task automatic t_start_empty;
    sel_par = 0; ser_wrap = 1; set_win(2, 4, 5, 6);
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0); exp_wr("R5", 1204);
  endtask

  task automatic t_port_select;
    sel_par = 0; ser_wrap = 1; par_stall = 0; set_win(2, 4, 5, 6);
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0); exp_wr("R6", 1202);
    step(1, 0, 0, 0, 0); exp_wr("R6", 1203);
    step(0, 1, 0, 0, 0); exp_none("R10");
    sel_par = 1;
    step(1, 0, 0, 0, 0); exp_none("R10");
    step(0, 1, 0, 0, 0); exp_wr("R10", 1202);
    step(0, 1, 0, 0, 0); exp_wr("R10", 1203);
    step(0, 1, 0, 0, 0); exp_wr("R10", 1204);
    step(0, 1, 0, 0, 0); exp_wr("R10", 1442);
    sel_par = 0;
    step(0, 1, 0, 0, 0); exp_none("R10");
    step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0); exp_wr("R6", 1204);
  endtask

  task automatic t_parallel;
    sel_par = 0; par_stall = 0; set_win(2, 4, 5, 6);
    step(0, 0, 0, 0, 0);
    sel_par = 1;
    step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0); exp_wr("R9", 1202);
    step(0, 1, 0, 0, 0); exp_wr("R2", 1203);
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0); exp_wr("R8", 1204);
    step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0); exp_wr("R7", 1444);
    step(0, 1, 0, 0, 0); exp_wr("R7", 1202);
    par_stall = 1;
    step(0, 1, 0, 0, 0); exp_wr("R7", 1203);
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0); exp_wr("R8", 1202);
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0);
    exp_wr("R7", 1444);
    step(0, 1, 0, 0, 0); exp_none("R7");
    step(0, 1, 0, 0, 0); exp_none("R7");
    sel_par = 0;
    step(0, 0, 0, 0, 0);
    sel_par = 1;
    step(0, 1, 0, 0, 0); exp_wr("R9", 1202);
  endtask

  task automatic t_same_cycle;
    sel_par = 1; par_stall = 1; set_win(2, 4, 5, 6);
    step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0); exp_wr("R14", 1202);
    par_stall = 0;
    step(0, 1, 1, 0, 0); exp_wr("R14", 1203);
    sel_par = 0; ser_wrap = 1;
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0); exp_wr("R14", 1202);
    step(1, 0, 0, 0, 0); exp_wr("R14", 1203);
  endtask

  task automatic t_swap_clamp;
    sel_par = 0; ser_wrap = 1; mode_swap = 1; set_win(317, 319, 10, 11);
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0); exp_wr("R11", 76090);
    step(1, 0, 0, 0, 0); exp_wr("R11", 76330);
    step(1, 0, 0, 0, 0); exp_wr("R11", 76570);
    step(1, 0, 0, 0, 0); exp_wr("R11", 76091);
    mode_swap = 0; set_win(250, 260, 0, 0);
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0); exp_wr("R11", 239);
    step(1, 0, 0, 0, 0); exp_wr("R11", 239);
  endtask

  task automatic t_mirror;
    sel_par = 0; ser_wrap = 1; mode_swap = 0; set_win(2, 4, 5, 6);
    mirror_col = 1;
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0); exp_wr("R12", 1437);
    step(1, 0, 0, 0, 0); exp_wr("R12", 1436);
    mirror_col = 0; mirror_row = 1;
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0); exp_wr("R12", 75362);
    mirror_row = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    set_win(0, 239, 0, 319);
    mode_swap = 0; mirror_col = 0; mirror_row = 0; sel_par = 0;
    ser_wrap = 1; par_stall = 1;
    ser_start = 0; ser_cont = 0; ser_pix = 0; par_pix = 0; frame_sync = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_serial_wrap;
    t_serial_stall;
    t_start_empty;
    t_port_select;
    t_parallel;
    t_same_cycle;
    t_swap_clamp;
    t_mirror;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule